// File: doc/BRIEF.md
# Flash Prefetch Read Buffer

This block sits between a system bus and a serial-flash sequencer so that flash can be read with ordinary bus loads. It keeps one shared window of 32-bit words copied from flash. A load whose word is already in the window is answered from local storage. A load outside the window discards the window and starts a new read of the flash at the requested word. The length of that read is set by a programmable count of 8-byte units. The flash words that come back are written into storage in order. A load waits until its own word has arrived.

After the flash contents change, software makes the window stale by raising the bus-side and flash-side soft-reset inputs together. Doing so also abandons any refill still in progress. An optional byte reversal turns each returned 32-bit word end for end. While the disable input is high, no load is served.

Top module: `flash_prefetch_buf`

## Requirements
- R1: Out of reset the window is empty, and `busAck` and `seqStart` are low.
- R2: A load served while the window is empty or valid, whose word is not held, pulses `seqStart` for one cycle in the cycle after the load is sampled. With that pulse, `seqAddr` is the load's byte address (word address times 4) and `seqIdx` is the value of `cfgSeqIdx`.
- R3: A load whose word index lies in [base, base + words received) gets `busAck` high for one cycle in the cycle after it is sampled. `busData` then holds the flash word at that address, and `busData` changes only when a load is answered.
- R4: A load for a word that is not yet received, made during a refill, stalls with no new `seqStart`. It is acknowledged one cycle after it is sampled with its word present.
- R5: A load outside the window made during a refill waits until the refill completes, and then starts exactly one new fetch.
- R6: Starting a fetch drops every word of the previous window, so any load for a word outside the new window becomes a miss.
- R7: Raising `rstBusDom` and `rstFlashDom` together empties the window and abandons a refill in progress. Flash words that arrive later are ignored, and the next load starts a new fetch.
- R8: Raising only one of `rstBusDom` or `rstFlashDom` in a cycle has no effect on the window.
- R9: With `cfgSwap` high, `busData` is the stored word with byte 0 and byte 3 exchanged and byte 1 and byte 2 exchanged.
- R10: While `cfgDisable` is high, no load is acknowledged and no fetch starts. A pending load is served once `cfgDisable` falls.
- R11: The fetch length in `seqLen` is `cfgFetchUnits`×8 bytes. A value of 0 counts as one unit, and the length is capped at the 1024-byte capacity. No more words than that length are ever stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Load request, held until acknowledged |
| busAddr | input | ADDR_W | Word address of the load |
| busAck | output | 1 | One-cycle acknowledge of a load |
| busData | output | 32 | Load data, valid with `busAck` |
| cfgSeqIdx | input | 4 | Index of the flash read sequence to run on a miss |
| cfgFetchUnits | input | 8 | Fetch length in 8-byte units |
| cfgSwap | input | 1 | Reverse byte order of returned words |
| cfgDisable | input | 1 | Stop serving loads |
| rstBusDom | input | 1 | Bus-side soft reset |
| rstFlashDom | input | 1 | Flash-side soft reset |
| seqStart | output | 1 | One-cycle fetch request to the sequencer |
| seqIdx | output | 4 | Sequence index for the fetch |
| seqAddr | output | ADDR_W+2 | Byte address where the fetch starts |
| seqLen | output | $clog2(BUF_BYTES/4)+3 | Fetch length in bytes |
| flashValid | input | 1 | A fetched flash word is present |
| flashData | input | 32 | Fetched flash word |

## Verification
On every cycle, the embedded properties check the following:
- An acknowledge is always preceded by a request.
- Disable silences both the acknowledge and the fetch request.
- A paired soft reset leaves the window empty with no acknowledge.
- The fill count never passes the fetch length.
- Returned data holds still between answers.

The bench's scenarios are needed for the rest. These are the returned values themselves, the stall until a word arrives, and deferring an outside miss until the refill completes. They also cover the fact that late flash words after an invalidation are dropped, and that a single soft reset leaves hits intact.

// File: rtl/fpb_pkg.sv
package fpb_pkg;

  // Window life cycle: nothing held, refill running, refill complete.
  typedef enum logic [1:0] {
    WIN_EMPTY = 2'd0,
    WIN_FILL  = 2'd1,
    WIN_FULL  = 2'd2
  } winState_t;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic storeWord;   // write incoming flash word at the fill index
    logic answerLoad;  // register a word out to the bus
  } bufStrobe_t;

endpackage

// File: rtl/flash_prefetch_ctrl.sv
module flash_prefetch_ctrl
  import fpb_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int WORDS  = 256,
  parameter int IDX_W  = $clog2(WORDS),
  parameter int CNT_W  = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busReq,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [3:0]          cfgSeqIdx,
  input  logic [7:0]          cfgFetchUnits,
  input  logic                cfgDisable,
  input  logic                rstBusDom,
  input  logic                rstFlashDom,
  input  logic                flashValid,
  output logic                busAck,
  output logic                seqStart,
  output logic [3:0]          seqIdx,
  output logic [ADDR_W+1:0]   seqAddr,
  output logic [CNT_W+1:0]    seqLen,
  output bufStrobe_t          strobe,
  output logic [IDX_W-1:0]    wrIdx,
  output logic [IDX_W-1:0]    rdIdx
);

  winState_t          stateQ;
  logic [ADDR_W-1:0]  baseQ;
  logic [CNT_W-1:0]   fillCntQ, winLenQ, reqWords;
  logic [ADDR_W-1:0]  offset;
  logic [31:0]        rawWords;
  logic               ackQ, startQ;
  logic [3:0]         seqIdxQ;
  logic [ADDR_W+1:0]  seqAddrQ;
  logic [CNT_W+1:0]   seqLenQ;
  logic               invalidate, serve, held, hit, startFetch, storeNow;

  always_comb begin
    invalidate = rstBusDom & rstFlashDom;
    offset     = busAddr - baseQ;
    serve      = busReq & ~ackQ & ~cfgDisable & ~invalidate;
    held       = offset < ADDR_W'(fillCntQ);
    hit        = serve & (stateQ != WIN_EMPTY) & held;
    startFetch = serve & ~hit & (stateQ != WIN_FILL);
    storeNow   = (stateQ == WIN_FILL) & flashValid & ~invalidate;
    rawWords   = (cfgFetchUnits == 8'd0) ? 32'd2 : {23'd0, cfgFetchUnits, 1'b0};
    reqWords   = (rawWords > 32'(WORDS)) ? CNT_W'(WORDS) : CNT_W'(rawWords);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= WIN_EMPTY;
      baseQ    <= '0;
      fillCntQ <= '0;
      winLenQ  <= '0;
      ackQ     <= 1'b0;
      startQ   <= 1'b0;
      seqIdxQ  <= '0;
      seqAddrQ <= '0;
      seqLenQ  <= '0;
    end else begin
      ackQ   <= hit;
      startQ <= startFetch;
      if (invalidate) begin
        stateQ   <= WIN_EMPTY;
        fillCntQ <= '0;
      end else if (startFetch) begin
        stateQ   <= WIN_FILL;
        baseQ    <= busAddr;
        fillCntQ <= '0;
        winLenQ  <= reqWords;
        seqIdxQ  <= cfgSeqIdx;
        seqAddrQ <= {busAddr, 2'b00};
        seqLenQ  <= {reqWords, 2'b00};
      end else if (storeNow) begin
        fillCntQ <= fillCntQ + CNT_W'(1);
        if (fillCntQ + CNT_W'(1) == winLenQ) stateQ <= WIN_FULL;
      end
    end
  end

  assign busAck            = ackQ;
  assign seqStart          = startQ;
  assign seqIdx            = seqIdxQ;
  assign seqAddr           = seqAddrQ;
  assign seqLen            = seqLenQ;
  assign strobe.storeWord  = storeNow;
  assign strobe.answerLoad = hit;
  assign wrIdx             = fillCntQ[IDX_W-1:0];
  assign rdIdx             = offset[IDX_W-1:0];

  // R3
  ack_has_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    busAck |-> $past(busReq));

  // R10
  disable_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgDisable |=> (!busAck && !seqStart));

  // R7
  invalidate_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstBusDom && rstFlashDom) |=> (stateQ == WIN_EMPTY && !busAck));

  // R11
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCntQ <= winLenQ);

  // R4
  one_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqStart |=> !seqStart);

endmodule

// File: rtl/flash_prefetch_data.sv
module flash_prefetch_data
  import fpb_pkg::*;
#(
  parameter int WORDS = 256,
  parameter int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  bufStrobe_t       strobe,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic [31:0]      flashData,
  input  logic             cfgSwap,
  output logic [31:0]      busData
);

  logic [31:0] storeQ [WORDS];
  logic [31:0] rdDataQ;
  logic [31:0] rawWord;

  always_ff @(posedge clk) begin
    if (strobe.storeWord) storeQ[wrIdx] <= flashData;
  end

  assign rawWord = storeQ[rdIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataQ <= '0;
    end else if (strobe.answerLoad) begin
      rdDataQ <= cfgSwap ? {rawWord[7:0], rawWord[15:8], rawWord[23:16], rawWord[31:24]}
                         : rawWord;
    end
  end

  assign busData = rdDataQ;

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.answerLoad |=> $stable(busData));

endmodule

// File: rtl/flash_prefetch_buf.sv
module flash_prefetch_buf
  import fpb_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int BUF_BYTES = 1024,
  localparam int WORDS    = BUF_BYTES / 4,
  localparam int IDX_W    = $clog2(WORDS),
  localparam int CNT_W    = IDX_W + 1,
  localparam int LEN_W    = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              busAck,
  output logic [31:0]       busData,
  input  logic [3:0]        cfgSeqIdx,
  input  logic [7:0]        cfgFetchUnits,
  input  logic              cfgSwap,
  input  logic              cfgDisable,
  input  logic              rstBusDom,
  input  logic              rstFlashDom,
  output logic              seqStart,
  output logic [3:0]        seqIdx,
  output logic [ADDR_W+1:0] seqAddr,
  output logic [LEN_W-1:0]  seqLen,
  input  logic              flashValid,
  input  logic [31:0]       flashData
);

  bufStrobe_t       strobe;
  logic [IDX_W-1:0] wrIdx, rdIdx;

  flash_prefetch_ctrl #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busAddr(busAddr),
    .cfgSeqIdx(cfgSeqIdx), .cfgFetchUnits(cfgFetchUnits), .cfgDisable(cfgDisable),
    .rstBusDom(rstBusDom), .rstFlashDom(rstFlashDom), .flashValid(flashValid),
    .busAck(busAck), .seqStart(seqStart), .seqIdx(seqIdx), .seqAddr(seqAddr),
    .seqLen(seqLen), .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx)
  );

  flash_prefetch_data #(.WORDS(WORDS)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .flashData(flashData), .cfgSwap(cfgSwap), .busData(busData)
  );

endmodule

// File: tb/flash_prefetch_buf_bench.sv
module flash_prefetch_buf_bench;
  localparam int AW = 22;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN, busReq, busAck, cfgSwap, cfgDisable, rstBusDom, rstFlashDom;
  logic [AW-1:0] busAddr;
  logic [31:0]   busData, flashData;
  logic [3:0]    cfgSeqIdx, seqIdx;
  logic [7:0]    cfgFetchUnits;
  logic          seqStart, flashValid;
  logic [AW+1:0] seqAddr;
  logic [10:0]   seqLen;

  flash_prefetch_buf u_flash_prefetch_buf (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busAddr(busAddr), .busAck(busAck),
    .busData(busData), .cfgSeqIdx(cfgSeqIdx), .cfgFetchUnits(cfgFetchUnits),
    .cfgSwap(cfgSwap), .cfgDisable(cfgDisable), .rstBusDom(rstBusDom),
    .rstFlashDom(rstFlashDom), .seqStart(seqStart), .seqIdx(seqIdx),
    .seqAddr(seqAddr), .seqLen(seqLen), .flashValid(flashValid), .flashData(flashData)
  );

  int checks = 0, failures = 0;
  string curReq = "R1";
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] flashWord(input int unsigned a);
    return (a * 32'h01000193) ^ 32'hC3A50000;
  endfunction

  function automatic logic [31:0] swap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // Flash sequencer stand-in and start monitor.
  int cyc = 0, gapN = 1, startCount = 0, rLeft = 0;
  int unsigned rAddr = 0, lastAddr = 0, lastLen = 0, lastIdx = 0;
  bit holdFlash = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      rLeft = 0;
      flashValid = 1'b0;
      flashData = '0;
    end else begin
      if (seqStart) begin
        startCount++;
        lastAddr = seqAddr; lastLen = seqLen; lastIdx = seqIdx;
        rAddr = seqAddr; rLeft = int'(seqLen) / 4;
      end
      if (rLeft > 0 && !holdFlash && (cyc % gapN) == 0) begin
        flashValid = 1'b1;
        flashData = flashWord(rAddr);
        rAddr += 4; rLeft--;
      end else begin
        flashValid = 1'b0;
      end
    end
  end

  // Behavioural reference model, advanced on each rising edge.
  int mState = 0, mBase = 0, mFill = 0, mWin = 0;
  logic [31:0] mBuf[$];
  logic expAck = 0, expStart = 0;
  logic [31:0] expData = '0;
  int unsigned expAddr = 0, expLen = 0, expIdx = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mFill = 0; mBuf.delete(); expAck = 0; expStart = 0;
    end else begin
      int orig, off, words;
      bit nAck, nStart, srv;
      orig = mState; nAck = 0; nStart = 0;
      if (rstBusDom && rstFlashDom) begin
        mState = 0; mFill = 0; mBuf.delete();
      end else begin
        off = int'(busAddr) - mBase;
        srv = busReq && !expAck && !cfgDisable;
        if (srv && orig != 0 && off >= 0 && off < mFill) begin
          nAck = 1;
          expData = cfgSwap ? swap32(mBuf[off]) : mBuf[off];
        end else if (srv && orig != 1) begin
          nStart = 1;
          words = (cfgFetchUnits == 0) ? 2 : int'(cfgFetchUnits) * 2;
          if (words > 256) words = 256;
          expAddr = int'(busAddr) * 4; expLen = words * 4; expIdx = cfgSeqIdx;
          mBase = int'(busAddr); mWin = words; mFill = 0; mBuf.delete(); mState = 1;
        end
        if (orig == 1 && flashValid) begin
          mBuf.push_back(flashData);
          mFill++;
          if (mFill == mWin) mState = 2;
        end
      end
      expAck = nAck; expStart = nStart;
    end
  end

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rstN === 1'b1 && !done) begin
      chk(busAck === expAck, {curReq, " busAck"}, busAck, expAck);
      chk(seqStart === expStart, {curReq, " seqStart"}, seqStart, expStart);
      if (expAck) chk(busData === expData, {curReq, " busData"}, busData, expData);
      if (expStart) begin
        chk(seqAddr === (AW+2)'(expAddr), {curReq, " seqAddr"}, seqAddr, expAddr);
        chk(seqLen === 11'(expLen), {curReq, " seqLen"}, seqLen, expLen);
        chk(seqIdx === 4'(expIdx), {curReq, " seqIdx"}, seqIdx, expIdx);
      end
    end
  end

  task automatic doRead(input int unsigned wa, output logic [31:0] d, output int lat);
    @(negedge clk);
    busReq = 1'b1; busAddr = AW'(wa); lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!busAck && lat < 3000);
    d = busData;
    busReq = 1'b0;
    #2;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired in %s", curReq);
    finishRun();
  end

  initial begin
    logic [31:0] d;
    int lat, s0;
    bit sawAck;
    rstN = 0; busReq = 0; busAddr = '0; cfgSeqIdx = 4'd5; cfgFetchUnits = 8'd4;
    cfgSwap = 0; cfgDisable = 0; rstBusDom = 0; rstFlashDom = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busAck === 1'b0, "R1 busAck in reset", busAck, 0);
    chk(seqStart === 1'b0, "R1 seqStart in reset", seqStart, 0);
    rstN = 1;

    // R2: first load misses an empty window
    curReq = "R2"; s0 = startCount;
    doRead(32'h40, d, lat);
    chk(startCount == s0 + 1, "R2 one fetch", startCount, s0 + 1);
    chk(lastAddr == 32'h100, "R2 seqAddr", lastAddr, 32'h100);
    chk(lastIdx == 5, "R2 seqIdx", lastIdx, 5);
    chk(lastLen == 32, "R11 seqLen 4 units", lastLen, 32);
    chk(d == flashWord(32'h100), "R3 miss data", d, flashWord(32'h100));
    idle(12);

    // R3: hits after the fill
    curReq = "R3"; s0 = startCount;
    doRead(32'h47, d, lat);
    chk(lat == 1, "R3 hit latency", lat, 1);
    chk(d == flashWord(32'h11C), "R3 hit data", d, flashWord(32'h11C));
    doRead(32'h42, d, lat);
    chk(d == flashWord(32'h108), "R3 hit data 2", d, flashWord(32'h108));
    chk(startCount == s0, "R3 no fetch on hit", startCount, s0);

    // R4: stall on a word not yet arrived
    curReq = "R4"; gapN = 3; s0 = startCount;
    doRead(32'h80, d, lat);
    doRead(32'h87, d, lat);
    chk(d == flashWord(32'h21C), "R4 stalled data", d, flashWord(32'h21C));
    chk(lat > 1, "R4 stalled", lat, 2);
    chk(startCount == s0 + 1, "R4 no second fetch", startCount, s0 + 1);

    // R5: outside load during refill waits for completion
    curReq = "R5"; gapN = 4; s0 = startCount;
    doRead(32'hC0, d, lat);
    doRead(32'h10, d, lat);
    chk(lat >= 20, "R5 deferred miss", lat, 20);
    chk(startCount == s0 + 2, "R5 fetch count", startCount, s0 + 2);
    chk(lastAddr == 32'h40, "R5 new fetch addr", lastAddr, 32'h40);
    chk(d == flashWord(32'h40), "R5 data", d, flashWord(32'h40));
    gapN = 1; idle(40);

    // R6: previous window is gone
    curReq = "R6"; s0 = startCount;
    doRead(32'hC0, d, lat);
    chk(startCount == s0 + 1, "R6 old window misses", startCount, s0 + 1);
    idle(12);
    doRead(32'h11, d, lat);
    chk(startCount == s0 + 2, "R6 second old window misses", startCount, s0 + 2);
    idle(12);

    // R11: zero units and clamp
    curReq = "R11"; cfgFetchUnits = 8'd0; s0 = startCount;
    doRead(32'h200, d, lat);
    chk(lastLen == 8, "R11 zero units length", lastLen, 8);
    idle(5);
    doRead(32'h202, d, lat);
    chk(startCount == s0 + 2, "R11 short window", startCount, s0 + 2);
    idle(5);
    cfgFetchUnits = 8'd200;
    doRead(32'h300, d, lat);
    chk(lastLen == 1024, "R11 capped length", lastLen, 1024);
    idle(300);
    doRead(32'h3FF, d, lat);
    chk(lat == 1 && d == flashWord(32'hFFC), "R11 last word hit", d, flashWord(32'hFFC));
    cfgFetchUnits = 8'd4;

    // R9: byte swap
    curReq = "R9"; cfgSwap = 1;
    doRead(32'h3F0, d, lat);
    chk(d == swap32(flashWord(32'hFC0)), "R9 swapped", d, swap32(flashWord(32'hFC0)));
    cfgSwap = 0;

    // R10: disable blocks service
    curReq = "R10"; s0 = startCount; sawAck = 0;
    @(negedge clk);
    cfgDisable = 1; busReq = 1; busAddr = AW'(32'h500);
    repeat (6) begin
      @(negedge clk);
      if (busAck) sawAck = 1;
    end
    chk(!sawAck, "R10 no ack while disabled", sawAck, 0);
    chk(startCount == s0, "R10 no fetch while disabled", startCount, s0);
    cfgDisable = 0; lat = 0;
    do begin @(negedge clk); lat++; end while (!busAck && lat < 100);
    d = busData; busReq = 0; #2;
    chk(d == flashWord(32'h1400), "R10 served after enable", d, flashWord(32'h1400));
    idle(15);

    // R8: a single soft reset leaves the window
    curReq = "R8"; s0 = startCount;
    @(negedge clk); rstBusDom = 1;
    @(negedge clk); rstBusDom = 0; rstFlashDom = 1;
    @(negedge clk); rstFlashDom = 0;
    doRead(32'h503, d, lat);
    chk(lat == 1, "R8 still hits", lat, 1);
    chk(startCount == s0, "R8 no refetch", startCount, s0);
    chk(d == flashWord(32'h140C), "R8 data", d, flashWord(32'h140C));

    // R7: paired soft reset abandons refill
    curReq = "R7"; gapN = 5; s0 = startCount;
    doRead(32'h600, d, lat);
    @(negedge clk); rstBusDom = 1; rstFlashDom = 1;
    repeat (2) @(negedge clk);
    rstBusDom = 0; rstFlashDom = 0;
    idle(45);
    gapN = 1;
    doRead(32'h601, d, lat);
    chk(startCount == s0 + 2, "R7 refetch after invalidate", startCount, s0 + 2);
    chk(d == flashWord(32'h1804), "R7 data", d, flashWord(32'h1804));
    idle(12);
    @(negedge clk); rstBusDom = 1; rstFlashDom = 1;
    @(negedge clk); rstBusDom = 0; rstFlashDom = 0;
    doRead(32'h602, d, lat);
    chk(startCount == s0 + 3, "R7 full window invalidated", startCount, s0 + 3);
    idle(12);

    finishRun();
  end

endmodule